// File: doc/BRIEF.md
# QoS-aware virtual channel switch arbiter

This block decides, cycle by cycle, which of four input virtual channels may move its front flit through the router switch toward one output port. Each channel presents a request and its current 35-bit flit. A header flit carries a service class (guaranteed or best-effort) and a two-bit priority. The arbiter keeps one priority register per channel, reloaded from every header the channel forwards. Once a channel wins, it keeps the switch until its tail flit has passed.

Three modes are available. The fair mode rotates among the requesters and ignores class. The pre-emptive mode grants the highest current level, and a guaranteed packet with a strictly higher level may take the switch from the holder. The inheritance mode also grants by level but never pre-empts. In this mode, while an outside conflict sensor reports a blocked guaranteed packet, waiting best-effort channels are lifted to that packet's level, so they can use the path that the blocked packet cannot.

The grant is combinational from the current requests, flits and state. A channel's flit crosses the switch in every cycle its grant bit is high.

Top module: `vc_qos_arb`

## Requirements
- R1: `gnt` has at most one bit set, and a bit is set only for a channel whose `req` bit is high; an owner that drops its request receives no grant and keeps ownership.
- R2: Flit bits 34:32 hold the flit kind: 3'b010 header, 3'b100 tail, any other code body. In a header, bit 22 is 1 for guaranteed and 0 for best-effort, and bits 21:20 hold the priority p. A guaranteed header gives level p+1; best-effort is level 0.
- R3: In mode 2'b00 (and 2'b11), a free switch goes to the first requester at or after a rotating pointer, and the class is ignored. The winner holds the switch until its tail passes.
- R4: In modes 2'b01 and 2'b10, a free switch goes to the requester with the highest current level. Ties go to the first in rotation from the pointer. After each new owner, the pointer moves to the channel just past it.
- R5: In mode 2'b01, a requester whose level comes from a guaranteed class and is strictly above the holder's level takes the switch in that same cycle. Best-effort requesters and requesters at an equal level never take it.
- R6: A channel that loses the switch to pre-emption keeps its place. When it wins again, its next flit is granted, using its stored level.
- R7: In mode 2'b10, while `blk_req` is high, each waiting best-effort requester is raised to level `blk_prio`+1 from the next cycle. A holder is never displaced in this mode.
- R8: A raised level drops back to the base level after the raised channel's tail passes, or after `blk_req` falls.
- R9: A new value on `mode_cfg` is adopted only at a clock edge after which no channel holds the switch.
- R10: After reset no channel holds the switch, the pointer is at channel 0 and the mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 2 | Requested mode: 00 fair, 01 pre-emptive, 10 inheritance, 11 fair |
| req | input | 4 | Per-channel flit-ready request |
| flits | input | 140 | Front flit of each channel, channel i at bits 35*i+34 down to 35*i |
| blk_req | input | 1 | Conflict sensor: a guaranteed packet is blocked by a higher one |
| blk_prio | input | 2 | Priority field of that blocked packet |
| gnt | output | 4 | One-hot grant; the flagged channel's flit crosses this cycle |

## Verification
The bench tests the cases where ownership is contested. A best-effort or equal-level request arrives in the middle of a packet: a design that let it through would show the grant moving before the tail. A higher guaranteed header pre-empts and the loser later resumes: a design that dropped the loser would never grant it again. It also changes the mode in the middle of a packet, which a design that applied it at once would reveal by the wrong winner at the next free arbitration. The bench also checks that an inherited level outlives neither the promoted packet nor the conflict, which a sticky design would show by beating a guaranteed requester it should lose to.

// File: rtl/vc_qos_arb.sv
module vc_qos_arb #(
  parameter int NVC = 4,
  parameter int FW  = 35,
  parameter int PW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_cfg,
  input  logic [NVC-1:0]    req,
  input  logic [NVC*FW-1:0] flits,
  input  logic              blk_req,
  input  logic [PW-1:0]     blk_prio,
  output logic [NVC-1:0]    gnt
);
  localparam int IW = $clog2(NVC);
  localparam int LW = PW + 1;
  localparam int KIND_LO = 32;
  localparam int CLS_BIT = 22;
  localparam int PRI_LO  = 20;
  localparam logic [2:0] K_HDR  = 3'b010;
  localparam logic [2:0] K_TAIL = 3'b100;
  localparam logic [1:0] M_PRE = 2'b01;
  localparam logic [1:0] M_INH = 2'b10;

  logic [1:0]    mode_q;
  logic          own_v;
  logic [IW-1:0] own_q, rr_ptr;
  logic [NVC-1:0] is_hdr, is_tail, inh_q;
  logic [LW-1:0] hdr_lvl [NVC];
  logic [LW-1:0] base    [NVC];
  logic [LW-1:0] eff     [NVC];
  logic [LW-1:0] prio_q  [NVC];
  logic [LW-1:0] inh_lvl [NVC];

  for (genvar i = 0; i < NVC; i++) begin : g_dec
    logic [2:0] kind;
    assign kind       = flits[i*FW+KIND_LO +: 3];
    assign is_hdr[i]  = (kind == K_HDR);
    assign is_tail[i] = (kind == K_TAIL);
    assign hdr_lvl[i] = flits[i*FW+CLS_BIT] ?
                        LW'(flits[i*FW+PRI_LO +: PW]) + LW'(1) : '0;
    assign base[i]    = is_hdr[i] ? hdr_lvl[i] : prio_q[i];
    assign eff[i]     = inh_q[i] ? inh_lvl[i] : base[i];
  end

  wire prio_mode = (mode_q == M_PRE) || (mode_q == M_INH);

  logic          win_v, pre_v, take, nxt_own_v;
  logic [IW-1:0] win, pre, sel, idx;
  logic [LW-1:0] win_lv, pre_lv, lv;

  always_comb begin
    win_v = 1'b0; win = '0; win_lv = '0;
    pre_v = 1'b0; pre = '0; pre_lv = '0;
    idx = '0; lv = '0;
    for (int k = 0; k < NVC; k++) begin
      idx = rr_ptr + IW'(k);
      lv  = prio_mode ? eff[idx] : '0;
      if (req[idx] && (!win_v || lv > win_lv)) begin
        win_v = 1'b1; win = idx; win_lv = lv;
      end
      if (req[idx] && idx != own_q && base[idx] != '0 && eff[idx] > eff[own_q] &&
          (!pre_v || eff[idx] > pre_lv)) begin
        pre_v = 1'b1; pre = idx; pre_lv = eff[idx];
      end
    end
  end

  always_comb begin
    gnt = '0; take = 1'b0; sel = own_q;
    if (!own_v) begin
      if (win_v) begin gnt[win] = 1'b1; take = 1'b1; sel = win; end
    end else if (mode_q == M_PRE && pre_v) begin
      gnt[pre] = 1'b1; take = 1'b1; sel = pre;
    end else if (req[own_q]) begin
      gnt[own_q] = 1'b1;
    end
    nxt_own_v = (gnt != '0) ? ~|(gnt & is_tail) : own_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      own_v  <= 1'b0;
      own_q  <= '0;
      rr_ptr <= '0;
      inh_q  <= '0;
      for (int i = 0; i < NVC; i++) begin
        prio_q[i]  <= '0;
        inh_lvl[i] <= '0;
      end
    end else begin
      own_v <= nxt_own_v;
      own_q <= sel;
      if (!nxt_own_v) mode_q <= mode_cfg;
      if (take) rr_ptr <= sel + IW'(1);
      for (int i = 0; i < NVC; i++) begin
        if (gnt[i] && is_hdr[i]) prio_q[i] <= hdr_lvl[i];
        if (!blk_req || mode_q != M_INH || (gnt[i] && is_tail[i])) begin
          inh_q[i] <= 1'b0;
        end else if (!inh_q[i] && req[i] && !gnt[i] && base[i] == '0) begin
          inh_q[i]   <= 1'b1;
          inh_lvl[i] <= LW'(blk_prio) + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vc_qos_arb_chk.sv
module vc_qos_arb_chk #(
  parameter int NVC = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NVC-1:0] req,
  input logic [NVC-1:0] gnt,
  input logic [NVC-1:0] is_tail,
  input logic [1:0]     mode_q,
  input logic           own_v
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_gnt_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R3, R7: outside pre-emptive mode a packet in flight is never displaced
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b01 && (gnt & ~is_tail) != '0) |=> (gnt & ~$past(gnt)) == '0);

  p_mode_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> !own_v);
endmodule

bind vc_qos_arb vc_qos_arb_chk #(.NVC(NVC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
  .is_tail(is_tail), .mode_q(mode_q), .own_v(own_v)
);

// File: tb/vc_qos_arb_test.sv
module vc_qos_arb_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_cfg;
  logic [3:0]   req;
  logic         blk_req;
  logic [1:0]   blk_prio;
  logic [3:0]   gnt;
  logic [34:0]  f [4];
  logic [139:0] flits;
  int checks = 0;
  int fails  = 0;

  assign flits = {f[3], f[2], f[1], f[0]};
  always #10 clk = ~clk;

  vc_qos_arb uut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .req(req), .flits(flits),
    .blk_req(blk_req), .blk_prio(blk_prio), .gnt(gnt)
  );

  // kind: 0 body, 1 header, 2 tail (R2 codes)
  function automatic logic [34:0] mk(input int kind, input bit gt, input logic [1:0] p);
    logic [34:0] r;
    r = '0;
    r[34:32] = (kind == 1) ? 3'b010 : (kind == 2) ? 3'b100 : 3'b000;
    r[22]    = gt;
    r[21:20] = p;
    r[7:0]   = 8'h5A;
    return r;
  endfunction

  // table kind: 0 body, 1 BE header, 2 tail, 3 GT header prio 3
  function automatic logic [34:0] tk(input logic [1:0] k);
    return (k == 2'd3) ? mk(1, 1'b1, 2'd3) : mk(int'(k), 1'b0, 2'd0);
  endfunction

  // {req, kind3, kind2, kind1, kind0, expected gnt}
  localparam logic [15:0] RRV [17] = '{
    16'b1111_01010101_0001, 16'b1111_01010100_0001, 16'b1111_01010110_0001,
    16'b1110_01010101_0010, 16'b1110_01011001_0010, 16'b1111_01010101_0100,
    16'b1111_01100101_0100, 16'b1011_01010101_1000, 16'b1011_10010101_1000,
    16'b0010_01010101_0010, 16'b0000_01010101_0000, 16'b0101_01010101_0000,
    16'b0111_01011001_0010, 16'b0101_01010101_0100, 16'b0101_01100101_0100,
    16'b1001_01010111_1000, 16'b1001_10010111_1000
  };

  task automatic step(input logic [3:0] e, input string tag);
    #5;
    checks++;
    if (gnt !== e) begin
      fails++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, e);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; blk_req = 1'b0; blk_prio = '0;
    for (int v = 0; v < 4; v++) f[v] = mk(0, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mode_cfg = 2'b00;
    @(negedge clk);
    do_reset();

    // R3 R1: rotation, hold to tail, class ignored in fair mode
    for (int n = 0; n < 17; n++) begin
      req = RRV[n][15:12];
      for (int v = 0; v < 4; v++) f[v] = tk(RRV[n][4 + 2*v +: 2]);
      step(RRV[n][3:0], (n == 10 || n == 11) ? "R1 R3 hold" : "R3 rotate");
    end

    // R10: fair mode right after reset even if priority mode requested
    mode_cfg = 2'b01;
    do_reset();
    req = 4'b0011; f[0] = mk(1, 1'b0, 2'd0); f[1] = mk(1, 1'b1, 2'd1);
    step(4'b0001, "R10 reset mode/pointer");

    // pre-emptive mode
    do_reset();
    step(4'b0000, "R1 idle");
    req = 4'b0011; f[0] = mk(1, 1'b0, 2'd0); f[1] = mk(1, 1'b1, 2'd1);
    step(4'b0010, "R2 R4 highest level");
    f[1] = mk(0, 1'b0, 2'd0); mode_cfg = 2'b00;
    step(4'b0010, "R5 best-effort cannot pre-empt");
    req = 4'b0111; f[2] = mk(1, 1'b1, 2'd3);
    step(4'b0100, "R5 R9 pre-empt, mode change deferred");
    f[2] = mk(0, 1'b0, 2'd0);
    step(4'b0100, "R5 pre-emptor holds");
    f[2] = mk(2, 1'b0, 2'd0);
    step(4'b0100, "R5 pre-emptor tail");
    req = 4'b0011;
    step(4'b0001, "R9 fair mode after boundary");
    f[0] = mk(2, 1'b0, 2'd0);
    step(4'b0001, "R3 tail");
    req = 4'b0010;
    step(4'b0010, "R6 pre-empted channel resumes");
    f[1] = mk(2, 1'b0, 2'd0); mode_cfg = 2'b01;
    step(4'b0010, "R6 resumed tail");
    req = 4'b0011; f[0] = mk(1, 1'b1, 2'd2); f[1] = mk(1, 1'b1, 2'd2);
    step(4'b0001, "R4 tie by pointer");
    f[0] = mk(0, 1'b0, 2'd0);
    step(4'b0001, "R5 equal level no pre-empt");
    f[0] = mk(2, 1'b0, 2'd0);
    step(4'b0001, "R5 tail");
    req = 4'b0010;
    step(4'b0010, "R4 remaining requester");

    // inheritance mode
    mode_cfg = 2'b10;
    do_reset();
    step(4'b0000, "R1 idle");
    req = 4'b0011; f[0] = mk(1, 1'b1, 2'd1); f[1] = mk(1, 1'b0, 2'd0);
    step(4'b0001, "R4 guaranteed first");
    req = 4'b1001; f[0] = mk(0, 1'b0, 2'd0); f[3] = mk(1, 1'b0, 2'd0);
    blk_req = 1'b1; blk_prio = 2'd3;
    step(4'b0001, "R7 holder kept");
    f[0] = mk(2, 1'b0, 2'd0);
    step(4'b0001, "R7 holder tail");
    req = 4'b1010; f[1] = mk(1, 1'b1, 2'd0);
    step(4'b1000, "R7 raised best-effort wins");
    f[3] = mk(0, 1'b0, 2'd0);
    step(4'b1000, "R7 raised holds");
    f[3] = mk(2, 1'b0, 2'd0);
    step(4'b1000, "R7 raised tail");
    f[3] = mk(1, 1'b0, 2'd0);
    step(4'b0010, "R8 dropped after finish");
    f[1] = mk(2, 1'b0, 2'd0); blk_req = 1'b0;
    step(4'b0010, "R7 no pre-emption in inheritance mode");
    f[1] = mk(1, 1'b1, 2'd0);
    step(4'b0010, "R8 dropped after unblock");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule